// File: doc/BRIEF.md
# Private L0 Line Coherence Controller

This block tracks the coherence state of one line in a private level-0 cache that sits beneath a private level-1 cache. It accepts requests from the processor (load, instruction fetch, store, replacement) and messages from the level-1 side (invalidate, forwarded reads and writes, fills, acknowledgements). It answers with outgoing requests and responses on a single valid/ready channel, and with completion and eviction strobes toward the core. The line keeps one of four stable states (invalid, shared, exclusive, modified) or one of four transient states while a request is outstanding. Those four are: fetch-fill pending, load-fill pending, write-miss pending, and upgrade pending.

A message from the level-1 side always wins over a processor request presented in the same cycle. Any transition that produces an outgoing message is taken only when the single message slot is empty, so a stalled channel holds the line where it is. Each outgoing message becomes visible a fixed number of cycles after the event that created it. Tags, data storage and the network are outside this block. Outgoing messages carry a flag that says whether a data block travels with them, and a dirty flag.

Top module: `lmc_top`

## Requirements
- R1: While and after reset, state_o is 0 (invalid), dirty_o is 0, msg_valid_o is 0 and all strobes are 0.
- R2: From invalid, a load (cpu_op 0) sends GETS (msg_kind 0) and enters state 5; a fetch (op 1) sends GETS and enters state 4; a store (op 2) sends GETX (kind 1) and enters state 6. A replacement (op 3) in invalid is consumed with no effect.
- R3: In any transient state (codes 4 to 7), cpu_ready_o is 0 for every operation, and the request is held until the line leaves that state.
- R4: In states 4 or 5, plain data (net_kind 4) leads to shared (1), exclusive data (5) leads to exclusive (2), and stale data (6) leads to invalid (0). Each of these pulses rd_done_o and fill_o. In states 6 or 7, exclusive data leads to modified (3) with dirty set and pulses wr_done_o and fill_o.
- R5: A load or fetch in states 1 to 3 pulses rd_done_o with no message. A store in exclusive or modified moves the line to modified, sets dirty and pulses wr_done_o with no message.
- R6: A store in shared sends UPGRADE (kind 2) and enters state 7. An invalidate (net_kind 0) in state 7 is answered with an ack (kind 5) and moves the line to state 6.
- R7: An invalidate or forwarded write (net_kind 1, or 9 for a raced upgrade) in exclusive is answered with an ack and no data. In modified it is answered with a data message (kind 4) carrying the dirty flag. Both end in invalid with dirty cleared.
- R8: A forwarded read (net_kind 2 or 3) in exclusive or modified sends a data message with the current dirty flag, moves the line to shared and clears dirty.
- R9: Replacement in exclusive or modified sends PUTX (kind 3), which carries a data block only if the line was dirty, and ends in invalid. Replacement in shared goes to invalid with no message. The dirty bit is never set outside modified.
- R10: With EVICT_NOTIFY set, evict_o pulses on every move from shared, exclusive or modified to invalid caused by an invalidate, a forwarded write or a replacement.
- R11: An invalidate in states 0, 4, 5 or 6 is answered with an ack and leaves the state unchanged. Acks (net_kind 7), writeback acks (8) and events that have no transition in the current state are consumed with no effect.
- R12: A message becomes valid LAT-1 clock edges after the edge that accepted its event and stays stable until msg_ready_i is high. While it waits, any event that needs a new message is not accepted.
- R13: When net_valid_i is high, cpu_ready_o is 0.
- R14: perm_o is 0 in invalid, 1 (read only) in shared, exclusive and state 7, 2 (read-write) in modified, and 3 (busy) in states 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid_i | input | 1 | Processor request present |
| cpu_op_i | input | 2 | 0 load, 1 fetch, 2 store, 3 replacement |
| cpu_ready_o | output | 1 | Processor request accepted this cycle |
| net_valid_i | input | 1 | Level-1 message present |
| net_kind_i | input | 4 | Incoming message class (see R4 to R11) |
| net_ready_o | output | 1 | Level-1 message accepted this cycle |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Outgoing message taken |
| msg_kind_o | output | 3 | 0 GETS, 1 GETX, 2 UPGRADE, 3 PUTX, 4 data, 5 inv ack |
| msg_dirty_o | output | 1 | Dirty flag of the outgoing message |
| msg_has_data_o | output | 1 | Outgoing message carries a data block |
| rd_done_o | output | 1 | Load or fetch completed |
| wr_done_o | output | 1 | Store completed |
| fill_o | output | 1 | Completion came from a fill |
| evict_o | output | 1 | Eviction notice to the core |
| state_o | output | 3 | Line state code |
| dirty_o | output | 1 | Line dirty bit |
| perm_o | output | 2 | Access permission code |

## Verification
Several checks run on every cycle: the stall of processor requests in transient states, network priority, a waiting message held stable, and dirty or modified-only permission tied to the modified state. They also check that store completion lands in modified and that an eviction notice always coincides with the invalid state. Only the bench's scenarios can show that each event selects the correct message kind, dirty flag and data flag, and that message latency counts out exactly. The same goes for a stale fill ending invalid while still completing the load, a raced upgrade falling back to a write miss, and a stalled request being served once its fill lands.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  typedef enum logic [2:0] {
    LS_INV  = 3'd0,
    LS_SHR  = 3'd1,
    LS_EXC  = 3'd2,
    LS_MOD  = 3'd3,
    LS_FFIL = 3'd4,
    LS_LFIL = 3'd5,
    LS_WMIS = 3'd6,
    LS_UPGR = 3'd7
  } line_st_t;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_FETCH = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;
  localparam logic [1:0] OP_REPL  = 2'd3;

  localparam logic [3:0] NK_INV  = 4'd0;
  localparam logic [3:0] NK_FWX  = 4'd1;
  localparam logic [3:0] NK_FWS  = 4'd2;
  localparam logic [3:0] NK_FWI  = 4'd3;
  localparam logic [3:0] NK_DAT  = 4'd4;
  localparam logic [3:0] NK_DEX  = 4'd5;
  localparam logic [3:0] NK_STL  = 4'd6;
  localparam logic [3:0] NK_ACK  = 4'd7;
  localparam logic [3:0] NK_WBA  = 4'd8;
  localparam logic [3:0] NK_UPG  = 4'd9;

  localparam logic [2:0] MK_GETS = 3'd0;
  localparam logic [2:0] MK_GETX = 3'd1;
  localparam logic [2:0] MK_UPG  = 3'd2;
  localparam logic [2:0] MK_PUTX = 3'd3;
  localparam logic [2:0] MK_DATA = 3'd4;
  localparam logic [2:0] MK_IACK = 3'd5;

  typedef struct packed {
    logic       take;
    logic       need_msg;
    logic [2:0] msg_kind;
    logic       msg_dirty;
    logic       msg_data;
    line_st_t   nxt;
    logic       nxt_dirty;
    logic       rd;
    logic       wr;
    logic       fill;
    logic       ev;
  } act_t;

endpackage

// File: rtl/lmc_net_decide.sv
module lmc_net_decide
  import lmc_pkg::*;
(
  input  line_st_t   st,
  input  logic       dirty,
  input  logic [3:0] kind,
  output act_t       act
);

  always_comb begin
    act = '0;
    act.take = 1'b1;
    act.nxt = st;
    act.nxt_dirty = dirty;
    case (kind)
      NK_INV: begin
        act.need_msg = 1'b1;
        act.msg_kind = MK_IACK;
        case (st)
          LS_UPGR: act.nxt = LS_WMIS;
          LS_SHR, LS_EXC: begin
            act.nxt = LS_INV;
            act.nxt_dirty = 1'b0;
            act.ev = 1'b1;
          end
          LS_MOD: begin
            act.msg_kind = MK_DATA;
            act.msg_dirty = dirty;
            act.msg_data = 1'b1;
            act.nxt = LS_INV;
            act.nxt_dirty = 1'b0;
            act.ev = 1'b1;
          end
          default: ;
        endcase
      end
      NK_FWX, NK_UPG: begin
        if (st == LS_EXC) begin
          act.need_msg = 1'b1;
          act.msg_kind = MK_IACK;
          act.nxt = LS_INV;
          act.ev = 1'b1;
        end else if (st == LS_MOD) begin
          act.need_msg = 1'b1;
          act.msg_kind = MK_DATA;
          act.msg_dirty = dirty;
          act.msg_data = 1'b1;
          act.nxt = LS_INV;
          act.nxt_dirty = 1'b0;
          act.ev = 1'b1;
        end
      end
      NK_FWS, NK_FWI: begin
        if (st == LS_EXC || st == LS_MOD) begin
          act.need_msg = 1'b1;
          act.msg_kind = MK_DATA;
          act.msg_dirty = dirty;
          act.msg_data = 1'b1;
          act.nxt = LS_SHR;
          act.nxt_dirty = 1'b0;
        end
      end
      NK_DAT, NK_STL: begin
        if (st == LS_FFIL || st == LS_LFIL) begin
          act.nxt = (kind == NK_DAT) ? LS_SHR : LS_INV;
          act.nxt_dirty = 1'b0;
          act.rd = 1'b1;
          act.fill = 1'b1;
        end
      end
      NK_DEX: begin
        if (st == LS_FFIL || st == LS_LFIL) begin
          act.nxt = LS_EXC;
          act.nxt_dirty = 1'b0;
          act.rd = 1'b1;
          act.fill = 1'b1;
        end else if (st == LS_WMIS || st == LS_UPGR) begin
          act.nxt = LS_MOD;
          act.nxt_dirty = 1'b1;
          act.wr = 1'b1;
          act.fill = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lmc_cpu_decide.sv
module lmc_cpu_decide
  import lmc_pkg::*;
(
  input  line_st_t   st,
  input  logic       dirty,
  input  logic [1:0] op,
  output act_t       act
);

  always_comb begin
    act = '0;
    act.take = 1'b1;
    act.nxt = st;
    act.nxt_dirty = dirty;
    case (st)
      LS_INV: begin
        if (op != OP_REPL) begin
          act.need_msg = 1'b1;
          act.msg_kind = (op == OP_STORE) ? MK_GETX : MK_GETS;
          act.nxt = (op == OP_LOAD) ? LS_LFIL :
                    (op == OP_FETCH) ? LS_FFIL : LS_WMIS;
        end
      end
      LS_SHR, LS_EXC, LS_MOD: begin
        case (op)
          OP_LOAD, OP_FETCH: act.rd = 1'b1;
          OP_STORE: begin
            if (st == LS_SHR) begin
              act.need_msg = 1'b1;
              act.msg_kind = MK_UPG;
              act.nxt = LS_UPGR;
            end else begin
              act.nxt = LS_MOD;
              act.nxt_dirty = 1'b1;
              act.wr = 1'b1;
            end
          end
          default: begin
            act.nxt = LS_INV;
            act.nxt_dirty = 1'b0;
            act.ev = 1'b1;
            if (st != LS_SHR) begin
              act.need_msg = 1'b1;
              act.msg_kind = MK_PUTX;
              act.msg_dirty = dirty;
              act.msg_data = dirty;
            end
          end
        endcase
      end
      default: act.take = 1'b0;
    endcase
  end

endmodule

// File: rtl/lmc_msg_slot.sv
module lmc_msg_slot #(
  parameter int LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] kind_in,
  input  logic       dirty_in,
  input  logic       data_in,
  input  logic       ready,
  output logic       full,
  output logic       valid,
  output logic [2:0] kind,
  output logic       dirty,
  output logic       has_data
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] wait_q;

  assign valid = full && (wait_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      wait_q   <= '0;
      kind     <= '0;
      dirty    <= 1'b0;
      has_data <= 1'b0;
    end else if (load) begin
      full     <= 1'b1;
      wait_q   <= CW'(LAT - 1);
      kind     <= kind_in;
      dirty    <= dirty_in;
      has_data <= data_in;
    end else if (full) begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      else if (ready) full <= 1'b0;
    end
  end

endmodule

// File: rtl/lmc_top.sv
module lmc_top
  import lmc_pkg::*;
#(
  parameter int LAT          = 2,
  parameter bit EVICT_NOTIFY = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_valid_i,
  input  logic [1:0] cpu_op_i,
  output logic       cpu_ready_o,
  input  logic       net_valid_i,
  input  logic [3:0] net_kind_i,
  output logic       net_ready_o,
  output logic       msg_valid_o,
  input  logic       msg_ready_i,
  output logic [2:0] msg_kind_o,
  output logic       msg_dirty_o,
  output logic       msg_has_data_o,
  output logic       rd_done_o,
  output logic       wr_done_o,
  output logic       fill_o,
  output logic       evict_o,
  output logic [2:0] state_o,
  output logic       dirty_o,
  output logic [1:0] perm_o
);

  line_st_t st_q;
  logic     dirty_q;
  act_t     net_act, cpu_act, sel;
  logic     slot_full, net_ok, cpu_ok, fire;

  lmc_net_decide net_dec_i (.st(st_q), .dirty(dirty_q), .kind(net_kind_i), .act(net_act));
  lmc_cpu_decide cpu_dec_i (.st(st_q), .dirty(dirty_q), .op(cpu_op_i), .act(cpu_act));

  assign net_ready_o = !(net_act.need_msg && slot_full);
  assign cpu_ready_o = !net_valid_i && cpu_act.take && !(cpu_act.need_msg && slot_full);
  assign net_ok = net_valid_i && net_ready_o;
  assign cpu_ok = cpu_valid_i && cpu_ready_o;
  assign fire   = net_ok || cpu_ok;
  assign sel    = net_ok ? net_act : cpu_act;

  lmc_msg_slot #(.LAT(LAT)) slot_i (
    .clk(clk), .rst(rst),
    .load(fire && sel.need_msg),
    .kind_in(sel.msg_kind), .dirty_in(sel.msg_dirty), .data_in(sel.msg_data),
    .ready(msg_ready_i),
    .full(slot_full), .valid(msg_valid_o),
    .kind(msg_kind_o), .dirty(msg_dirty_o), .has_data(msg_has_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LS_INV;
      dirty_q   <= 1'b0;
      rd_done_o <= 1'b0;
      wr_done_o <= 1'b0;
      fill_o    <= 1'b0;
      evict_o   <= 1'b0;
    end else begin
      rd_done_o <= fire && sel.rd;
      wr_done_o <= fire && sel.wr;
      fill_o    <= fire && sel.fill;
      evict_o   <= fire && sel.ev && EVICT_NOTIFY;
      if (fire) begin
        st_q    <= sel.nxt;
        dirty_q <= sel.nxt_dirty;
      end
    end
  end

  always_comb begin
    case (st_q)
      LS_INV:                  perm_o = 2'd0;
      LS_SHR, LS_EXC, LS_UPGR: perm_o = 2'd1;
      LS_MOD:                  perm_o = 2'd2;
      default:                 perm_o = 2'd3;
    endcase
  end

  assign state_o = st_q;
  assign dirty_o = dirty_q;

endmodule

// File: rtl/lmc_chk.sv
module lmc_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_valid_i,
  input logic       cpu_ready_o,
  input logic       net_valid_i,
  input logic       msg_valid_o,
  input logic       msg_ready_i,
  input logic [2:0] msg_kind_o,
  input logic       wr_done_o,
  input logic       evict_o,
  input logic [2:0] state_o,
  input logic       dirty_o,
  input logic [1:0] perm_o
);

  // R3
  stall_transient_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o[2] && cpu_valid_i) |-> !cpu_ready_o);

  // R13
  net_first_chk: assert property (@(posedge clk) disable iff (rst)
    net_valid_i |-> !cpu_ready_o);

  // R12
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_kind_o)));

  // R5
  store_done_mod_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done_o |-> (state_o == 3'd3 && dirty_o));

  // R9
  dirty_only_mod_chk: assert property (@(posedge clk) disable iff (rst)
    dirty_o |-> (state_o == 3'd3));

  // R10
  evict_to_inv_chk: assert property (@(posedge clk) disable iff (rst)
    evict_o |-> (state_o == 3'd0));

  // R14
  rw_perm_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (perm_o == 2'd2) |-> (state_o == 3'd3));

endmodule

bind lmc_top lmc_chk chk_i (
  .clk(clk), .rst(rst), .cpu_valid_i(cpu_valid_i), .cpu_ready_o(cpu_ready_o),
  .net_valid_i(net_valid_i), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_kind_o(msg_kind_o), .wr_done_o(wr_done_o), .evict_o(evict_o),
  .state_o(state_o), .dirty_o(dirty_o), .perm_o(perm_o)
);

// File: tb/lmc_top_tb_top.sv
module lmc_top_tb_top;

  localparam int LAT = 2;
  localparam bit EVN = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0, net_valid = 1'b0, msg_ready = 1'b1;
  logic [1:0] cpu_op = 2'd0;
  logic [3:0] net_kind = 4'd7;
  logic cpu_ready, net_ready, msg_valid, msg_dirty, msg_has_data;
  logic rd_done, wr_done, fill, evict, dirty;
  logic [2:0] msg_kind, state;
  logic [1:0] perm;

  always #10 clk = ~clk;

  lmc_top #(.LAT(LAT), .EVICT_NOTIFY(EVN)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_valid_i(cpu_valid), .cpu_op_i(cpu_op), .cpu_ready_o(cpu_ready),
    .net_valid_i(net_valid), .net_kind_i(net_kind), .net_ready_o(net_ready),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_kind_o(msg_kind),
    .msg_dirty_o(msg_dirty), .msg_has_data_o(msg_has_data),
    .rd_done_o(rd_done), .wr_done_o(wr_done), .fill_o(fill), .evict_o(evict),
    .state_o(state), .dirty_o(dirty), .perm_o(perm)
  );

  typedef struct {
    bit take, msg, mdirty, mdata, ndirty, rd, wr, fl, ev;
    int mkind, nst;
  } res_t;

  int vectors = 0, fails = 0;
  bit finished = 0;
  int m_st = 0, q_kind = 0, q_wait = 0;
  bit m_dirty = 0, q_full = 0, q_dirty = 0, q_data = 0;
  bit e_rd = 0, e_wr = 0, e_fl = 0, e_ev = 0;

  function automatic res_t decide(bit is_net, int code, int st, bit d);
    res_t r = '{take:1, msg:0, mdirty:0, mdata:0, ndirty:d, rd:0, wr:0, fl:0, ev:0, mkind:0, nst:st};
    bit filling = (st == 4 || st == 5);
    if (is_net) begin
      if (code == 0) begin
        r.msg = 1; r.mkind = 5;
        if (st == 7) r.nst = 6;
        else if (st == 1 || st == 2) begin r.nst = 0; r.ev = 1; end
        else if (st == 3) begin r.mkind = 4; r.mdirty = d; r.mdata = 1; r.nst = 0; r.ev = 1; r.ndirty = 0; end
      end else if (code == 1 || code == 9) begin
        if (st == 2) begin r.msg = 1; r.mkind = 5; r.nst = 0; r.ev = 1; end
        if (st == 3) begin r.msg = 1; r.mkind = 4; r.mdirty = d; r.mdata = 1; r.nst = 0; r.ev = 1; r.ndirty = 0; end
      end else if (code == 2 || code == 3) begin
        if (st == 2 || st == 3) begin r.msg = 1; r.mkind = 4; r.mdirty = d; r.mdata = 1; r.nst = 1; r.ndirty = 0; end
      end else if (code == 4 && filling) begin r.nst = 1; r.rd = 1; r.fl = 1; r.ndirty = 0; end
      else if (code == 6 && filling) begin r.nst = 0; r.rd = 1; r.fl = 1; r.ndirty = 0; end
      else if (code == 5) begin
        if (filling) begin r.nst = 2; r.rd = 1; r.fl = 1; r.ndirty = 0; end
        if (st == 6 || st == 7) begin r.nst = 3; r.wr = 1; r.fl = 1; r.ndirty = 1; end
      end
    end else begin
      if (st >= 4) r.take = 0;
      else if (st == 0) begin
        if (code == 0) begin r.msg = 1; r.mkind = 0; r.nst = 5; end
        if (code == 1) begin r.msg = 1; r.mkind = 0; r.nst = 4; end
        if (code == 2) begin r.msg = 1; r.mkind = 1; r.nst = 6; end
      end else begin
        if (code <= 1) r.rd = 1;
        else if (code == 2) begin
          if (st == 1) begin r.msg = 1; r.mkind = 2; r.nst = 7; end
          else begin r.nst = 3; r.ndirty = 1; r.wr = 1; end
        end else begin
          r.nst = 0; r.ev = 1; r.ndirty = 0;
          if (st != 1) begin r.msg = 1; r.mkind = 3; r.mdirty = d; r.mdata = d; end
        end
      end
    end
    return r;
  endfunction

  function automatic int perm_of(int st);
    if (st == 0) return 0;
    if (st == 3) return 2;
    if (st == 1 || st == 2 || st == 7) return 1;
    return 3;
  endfunction

  task automatic cycle(input string tag, output bit an, output bit ac);
    res_t rn, rc, r;
    bit exp_nr, exp_cr, qv, ok;
    rn = decide(1, int'(net_kind), m_st, m_dirty);
    rc = decide(0, int'(cpu_op), m_st, m_dirty);
    exp_nr = !(rn.msg && q_full);
    exp_cr = !net_valid && rc.take && !(rc.msg && q_full);
    qv = q_full && q_wait == 0;
    #2;
    vectors++;
    ok = (int'(state) == m_st) && (dirty == m_dirty) && (int'(perm) == perm_of(m_st)) &&
         (rd_done == e_rd) && (wr_done == e_wr) && (fill == e_fl) && (evict == e_ev) &&
         (msg_valid == qv) && (net_ready == exp_nr) && (cpu_ready == exp_cr) &&
         (!qv || (int'(msg_kind) == q_kind && msg_dirty == q_dirty && msg_has_data == q_data));
    if (!ok) begin
      fails++;
      $display("FAIL %s: got st=%0d d=%0b p=%0d rd=%0b wr=%0b f=%0b ev=%0b mv=%0b mk=%0d md=%0b mh=%0b nr=%0b cr=%0b; exp st=%0d d=%0b p=%0d rd=%0b wr=%0b f=%0b ev=%0b mv=%0b mk=%0d md=%0b mh=%0b nr=%0b cr=%0b",
        tag, state, dirty, perm, rd_done, wr_done, fill, evict, msg_valid, msg_kind, msg_dirty,
        msg_has_data, net_ready, cpu_ready, m_st, m_dirty, perm_of(m_st), e_rd, e_wr, e_fl, e_ev,
        qv, q_kind, q_dirty, q_data, exp_nr, exp_cr);
    end
    an = net_valid && exp_nr;
    ac = cpu_valid && exp_cr;
    e_rd = 0; e_wr = 0; e_fl = 0; e_ev = 0;
    if (qv && msg_ready) q_full = 0;
    else if (q_full && q_wait > 0) q_wait--;
    if (an || ac) begin
      r = an ? rn : rc;
      m_st = r.nst; m_dirty = r.ndirty;
      e_rd = r.rd; e_wr = r.wr; e_fl = r.fl; e_ev = r.ev && EVN;
      if (r.msg) begin
        q_full = 1; q_wait = LAT - 1; q_kind = r.mkind; q_dirty = r.mdirty; q_data = r.mdata;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    bit a, c;
    for (int i = 0; i < n; i++) cycle(tag, a, c);
  endtask

  task automatic net_ev(input logic [3:0] k, input string tag);
    bit a, c;
    net_valid = 1; net_kind = k;
    for (int i = 0; i < 40; i++) begin
      cycle(tag, a, c);
      if (a) break;
    end
    net_valid = 0;
  endtask

  task automatic cpu_ev(input logic [1:0] op, input string tag);
    bit a, c;
    cpu_valid = 1; cpu_op = op;
    for (int i = 0; i < 40; i++) begin
      cycle(tag, a, c);
      if (c) break;
    end
    cpu_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit a, c;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2, "R1");
    // load miss, latency, stall in fill, network priority
    cpu_ev(2'd0, "R2");
    idle(3, "R12");
    cpu_valid = 1; cpu_op = 2'd2;
    idle(3, "R3");
    net_valid = 1; net_kind = 4'd4;
    cycle("R13", a, c);
    net_valid = 0;
    cpu_ev(2'd2, "R6");
    idle(3, "R6");
    net_ev(4'd0, "R6");
    idle(3, "R11");
    net_ev(4'd5, "R4");
    idle(2, "R4");
    cpu_ev(2'd3, "R9");
    idle(3, "R10");
    // fetch, exclusive fill, silent store, forwarded read
    cpu_ev(2'd1, "R2");
    idle(3, "R2");
    net_ev(4'd5, "R4");
    cpu_ev(2'd1, "R5");
    cpu_ev(2'd2, "R5");
    idle(1, "R5");
    net_ev(4'd2, "R8");
    idle(3, "R8");
    cpu_ev(2'd3, "R9");
    idle(1, "R10");
    // write miss, invalidate while pending, forwarded write in M
    cpu_ev(2'd2, "R2");
    idle(3, "R2");
    net_ev(4'd0, "R11");
    idle(3, "R11");
    net_ev(4'd5, "R4");
    net_ev(4'd1, "R7");
    idle(3, "R7");
    // stale fill, ignored messages
    cpu_ev(2'd0, "R2");
    idle(3, "R2");
    net_ev(4'd6, "R4");
    net_ev(4'd7, "R11");
    net_ev(4'd8, "R11");
    cpu_ev(2'd3, "R2");
    net_ev(4'd0, "R11");
    idle(3, "R11");
    // exclusive then invalidate; raced upgrade as forwarded write
    cpu_ev(2'd0, "R2");
    idle(3, "R2");
    net_ev(4'd5, "R4");
    net_ev(4'd0, "R7");
    idle(3, "R7");
    cpu_ev(2'd1, "R2");
    idle(3, "R2");
    net_ev(4'd5, "R4");
    net_ev(4'd9, "R7");
    idle(3, "R7");
    // clean replacement from E
    cpu_ev(2'd0, "R2");
    idle(3, "R2");
    net_ev(4'd3, "R11");
    net_ev(4'd5, "R4");
    cpu_ev(2'd3, "R9");
    idle(3, "R9");
    // back-pressure on the outgoing channel
    msg_ready = 0;
    cpu_ev(2'd0, "R12");
    idle(4, "R12");
    net_valid = 1; net_kind = 4'd0;
    idle(3, "R12");
    msg_ready = 1;
    net_ev(4'd0, "R12");
    idle(4, "R12");
    net_ev(4'd4, "R4");
    net_ev(4'd2, "R11");
    cpu_ev(2'd0, "R5");
    idle(2, "R14");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule